// File: doc/BRIEF.md
# Power Gating Sequence Controller

This block runs on an always-on clock. It moves a switchable logic domain into a power-gated state and brings it back out. It starts the power-down in two cases. The first is a bus that has stayed quiet for a set number of always-on cycles, which is the suspend condition; 3 ms of inactivity is typical. The second is a session-valid input that drops. Power-down runs a fixed series of steps: isolation clamps on, domain reset on, clocks off, supply switch off. Each timed step lasts a programmable number of cycles. The supply steps wait for a power-good acknowledge instead.

While the domain is gated, the controller watches five wake event inputs. Any one of them starts the same steps in reverse order:

- supply on;
- clocks on;
- reset released;
- clamps released last.

When the hibernation input is set, a restore step is added after reset release. It issues a one-cycle restore strobe and waits for an acknowledge before the clamps drop. A wake event that arrives part-way through power-down lets the current step finish, then jumps straight into the matching wake-up step. The current sequence state is visible on a status output. A sticky register holds the events that triggered the most recent wake-up.

The block has no streaming data path. All pins are plain control and status levels.

Top module: `pwr_gate_seq`

## Requirements
- R1: While reset is applied and right after it, status is 0 (running), clamp_en=0, dom_rst=0, clk_en=1, pwr_sw_en=1, restore_req=0 and wake_cause=0.
- R2: In the running state (status 0), the controller moves to status 1 (clamping) in either of two cases. The first is one cycle after bus_active has been low for IDLE_CYCLES consecutive cycles. The second is the first clock edge at which session_ok is low. Otherwise it stays in status 0.
- R3: The timed power-down steps run in this order: status 1 (clamping), status 2 (reset held), status 3 (clocks stopped), status 4 (supply switching off). Each timed step lasts step_wait+1 cycles, where step_wait is the value sampled at the edge that entered the step.
- R4: Status 4 holds while pwr_good is high. It moves to status 5 (gated) on the edge after pwr_good reads low.
- R5: Status 5 holds while wake_evt is all zero. Any nonzero wake_evt moves it to status 6 (supply switching on). The wake_evt bits are: bit 0 resume, bit 1 remote wakeup, bit 2 bus reset, bit 3 session request, bit 4 new session start.
- R6: Wake-up runs in this order:
  - status 6 holds until pwr_good reads high;
  - status 7 (clocks running) lasts step_wait+1 cycles;
  - status 8 (reset released) lasts step_wait+1 cycles.
  After status 8 the controller enters status 0, with the clamps released, when hib_mode is low.
- R7: With hib_mode high, status 8 is followed by status 9 (restoring). restore_req is high only in the first cycle of status 9. Status 9 holds until restore_done is high, then returns to status 0.
- R8: Suppose a wake event is seen in status 1, 2, 3 or 4. That step finishes normally. The controller then goes to its reverse step instead of continuing down: 1 goes to 0, 2 goes to 8, 3 goes to 7, and 4 goes to 6.
- R9: wake_cause loads wake_evt at the first edge, outside status 0, at which wake_evt is nonzero and no wake is already pending. It holds that value until the next such capture.
- R10: In status 0, wake_evt has no effect on the status or on wake_cause.
- R11: The outputs are fixed by status, in the order clamp_en/dom_rst/clk_en/pwr_sw_en:
  - 0: 0/0/1/1
  - 1, 8, 9: 1/0/1/1
  - 2, 7: 1/1/1/1
  - 3, 6: 1/1/0/1
  - 4, 5: 1/1/0/0

  So reset only ever appears under clamps, clocks only stop under reset, and the supply only drops with clocks stopped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-on clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_active | input | 1 | High in any cycle with bus activity |
| session_ok | input | 1 | Session valid; low forces power-down |
| hib_mode | input | 1 | Enables the restore step on wake-up |
| step_wait | input | SW_W | Extra cycles for each timed step |
| wake_evt | input | 5 | Wake event lines (bit order in R5) |
| pwr_good | input | 1 | Supply acknowledge from the power switch |
| restore_done | input | 1 | Restore completion acknowledge |
| clamp_en | output | 1 | Isolation clamp enable |
| dom_rst | output | 1 | Active-high reset to the switched domain |
| clk_en | output | 1 | Clock enable for the switched domain |
| pwr_sw_en | output | 1 | Supply switch enable |
| restore_req | output | 1 | One-cycle restore request |
| state_o | output | 4 | Current status code |
| wake_cause | output | 5 | Sticky record of the triggering wake events |

## Verification
The properties assume the following about the environment:
- pwr_good follows pwr_sw_en with some delay;
- restore_done comes only after a restore request;
- wake events are level samples that may appear in any state.

The stimulus models the supply as a follower of the switch enable with a random lag of one to four cycles. It returns restore_done one to four cycles after the strobe. It injects wake events at random, both in the running state and during the power-down and wake-up sequences, so the reversal paths and the ignored-in-running case are both exercised. Quiet bus periods and session drops are drawn long and short enough that entry happens both through the idle timer and through the session input.

// File: rtl/pgs_pkg.sv
package pgs_pkg;
  localparam int NUM_WAKE = 5;

  typedef enum logic [3:0] {
    ST_RUN     = 4'd0,
    ST_CLAMP   = 4'd1,
    ST_HOLD    = 4'd2,
    ST_CLKSTOP = 4'd3,
    ST_SWOFF   = 4'd4,
    ST_GATED   = 4'd5,
    ST_SWON    = 4'd6,
    ST_CLKRUN  = 4'd7,
    ST_RELEASE = 4'd8,
    ST_RESTORE = 4'd9
  } pg_state_t;

  typedef struct packed {
    logic clamp;
    logic rst;
    logic clk;
    logic sw;
  } pg_ctl_t;

  function automatic pg_ctl_t ctl_of(pg_state_t s);
    case (s)
      ST_RUN:                        ctl_of = '{1'b0, 1'b0, 1'b1, 1'b1};
      ST_CLAMP, ST_RELEASE, ST_RESTORE: ctl_of = '{1'b1, 1'b0, 1'b1, 1'b1};
      ST_HOLD, ST_CLKRUN:            ctl_of = '{1'b1, 1'b1, 1'b1, 1'b1};
      ST_CLKSTOP, ST_SWON:           ctl_of = '{1'b1, 1'b1, 1'b0, 1'b1};
      default:                       ctl_of = '{1'b1, 1'b1, 1'b0, 1'b0};
    endcase
  endfunction
endpackage

// File: rtl/pgs_idle_timer.sv
module pgs_idle_timer #(
  parameter int LIMIT = 96
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clear,
  input  logic activity,
  output logic expired
);
  localparam int W = $clog2(LIMIT + 1);

  logic [W-1:0] cnt_q;

  assign expired = (cnt_q == W'(LIMIT));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                cnt_q <= '0;
    else if (clear || activity) cnt_q <= '0;
    else if (!expired)         cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/pgs_step_timer.sv
module pgs_step_timer #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic         done
);
  logic [W-1:0] cnt_q;

  assign done = (cnt_q == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     cnt_q <= '0;
    else if (load)  cnt_q <= load_val;
    else if (!done) cnt_q <= cnt_q - 1'b1;
  end
endmodule

// File: rtl/pgs_wake_capture.sv
module pgs_wake_capture
  import pgs_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                armed,
  input  logic [NUM_WAKE-1:0] evt,
  output logic                go,
  output logic [NUM_WAKE-1:0] cause
);
  logic pend_q;
  logic hit;

  assign hit = |evt;
  assign go  = pend_q | hit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= 1'b0;
      cause  <= '0;
    end else begin
      if (!armed)   pend_q <= 1'b0;
      else if (hit) pend_q <= 1'b1;
      if (armed && !pend_q && hit) cause <= evt;
    end
  end
endmodule

// File: rtl/pwr_gate_seq.sv
module pwr_gate_seq
  import pgs_pkg::*;
#(
  parameter int IDLE_CYCLES = 96,
  parameter int SW_W        = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                bus_active,
  input  logic                session_ok,
  input  logic                hib_mode,
  input  logic [SW_W-1:0]     step_wait,
  input  logic [NUM_WAKE-1:0] wake_evt,
  input  logic                pwr_good,
  input  logic                restore_done,
  output logic                clamp_en,
  output logic                dom_rst,
  output logic                clk_en,
  output logic                pwr_sw_en,
  output logic                restore_req,
  output logic [3:0]          state_o,
  output logic [NUM_WAKE-1:0] wake_cause
);
  pg_state_t state_q, state_d, last_q;
  logic      suspend, step_done, wake_go;
  pg_ctl_t   ctl;

  pgs_idle_timer #(.LIMIT(IDLE_CYCLES)) u_idle (
    .clk(clk), .rst_n(rst_n), .clear(state_q != ST_RUN),
    .activity(bus_active), .expired(suspend)
  );

  pgs_step_timer #(.W(SW_W)) u_step (
    .clk(clk), .rst_n(rst_n), .load(state_d != state_q),
    .load_val(step_wait), .done(step_done)
  );

  pgs_wake_capture u_wake (
    .clk(clk), .rst_n(rst_n), .armed(state_q != ST_RUN),
    .evt(wake_evt), .go(wake_go), .cause(wake_cause)
  );

  always_comb begin
    state_d = state_q;
    case (state_q)
      ST_RUN:     if (suspend || !session_ok) state_d = ST_CLAMP;
      ST_CLAMP:   if (step_done) state_d = wake_go ? ST_RUN : ST_HOLD;
      ST_HOLD:    if (step_done) state_d = wake_go ? ST_RELEASE : ST_CLKSTOP;
      ST_CLKSTOP: if (step_done) state_d = wake_go ? ST_CLKRUN : ST_SWOFF;
      ST_SWOFF:   if (!pwr_good) state_d = wake_go ? ST_SWON : ST_GATED;
      ST_GATED:   if (wake_go) state_d = ST_SWON;
      ST_SWON:    if (pwr_good) state_d = ST_CLKRUN;
      ST_CLKRUN:  if (step_done) state_d = ST_RELEASE;
      ST_RELEASE: if (step_done) state_d = hib_mode ? ST_RESTORE : ST_RUN;
      ST_RESTORE: if (restore_done) state_d = ST_RUN;
      default:    state_d = ST_RUN;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_RUN;
      last_q  <= ST_RUN;
    end else begin
      state_q <= state_d;
      last_q  <= state_q;
    end
  end

  assign ctl         = ctl_of(state_q);
  assign clamp_en    = ctl.clamp;
  assign dom_rst     = ctl.rst;
  assign clk_en      = ctl.clk;
  assign pwr_sw_en   = ctl.sw;
  assign restore_req = (state_q == ST_RESTORE) && (last_q != ST_RESTORE);
  assign state_o     = state_q;
endmodule

// File: rtl/pgs_checker.sv
module pgs_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       clamp_en,
  input logic       dom_rst,
  input logic       clk_en,
  input logic       pwr_sw_en,
  input logic       restore_req,
  input logic [3:0] state_o,
  input logic [4:0] wake_evt,
  input logic [4:0] wake_cause,
  input logic       pwr_good
);
  a_r11_rst_under_clamp: assert property (@(posedge clk) disable iff (!rst_n)
    dom_rst |-> clamp_en);
  a_r11_clk_stop_under_rst: assert property (@(posedge clk) disable iff (!rst_n)
    !clk_en |-> dom_rst);
  a_r11_sw_off_clk_off: assert property (@(posedge clk) disable iff (!rst_n)
    !pwr_sw_en |-> !clk_en);
  a_r7_restore_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    restore_req |=> !restore_req);
  a_r5_gated_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (state_o == 4'd5 && wake_evt == 5'd0) |=> state_o == 4'd5);
  a_r4_swoff_waits: assert property (@(posedge clk) disable iff (!rst_n)
    (state_o == 4'd4 && pwr_good) |=> state_o == 4'd4);
  a_r6_swon_waits: assert property (@(posedge clk) disable iff (!rst_n)
    (state_o == 4'd6 && !pwr_good) |=> state_o == 4'd6);
  a_r10_cause_kept_in_run: assert property (@(posedge clk) disable iff (!rst_n)
    (state_o == 4'd0) |=> $stable(wake_cause));
endmodule

bind pwr_gate_seq pgs_checker u_pgs_checker (
  .clk(clk), .rst_n(rst_n), .clamp_en(clamp_en), .dom_rst(dom_rst),
  .clk_en(clk_en), .pwr_sw_en(pwr_sw_en), .restore_req(restore_req),
  .state_o(state_o), .wake_evt(wake_evt), .wake_cause(wake_cause),
  .pwr_good(pwr_good)
);

// File: tb/test_pwr_gate_seq.sv
`timescale 1ns/1ps
module test_pwr_gate_seq;
  localparam int IDLE = 24;
  localparam int SWW  = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bus_active = 1'b1, session_ok = 1'b1, hib_mode = 1'b0;
  logic [SWW-1:0] step_wait = '0;
  logic [4:0] wake_evt = '0;
  logic pwr_good = 1'b1, restore_done = 1'b0;
  logic clamp_en, dom_rst, clk_en, pwr_sw_en, restore_req;
  logic [3:0] state_o;
  logic [4:0] wake_cause;

  pwr_gate_seq #(.IDLE_CYCLES(IDLE), .SW_W(SWW)) i_pwr_gate_seq (
    .clk(clk), .rst_n(rst_n), .bus_active(bus_active), .session_ok(session_ok),
    .hib_mode(hib_mode), .step_wait(step_wait), .wake_evt(wake_evt),
    .pwr_good(pwr_good), .restore_done(restore_done), .clamp_en(clamp_en),
    .dom_rst(dom_rst), .clk_en(clk_en), .pwr_sw_en(pwr_sw_en),
    .restore_req(restore_req), .state_o(state_o), .wake_cause(wake_cause)
  );

  always #2 clk = ~clk;

  int n_chk = 0, n_fail = 0;
  bit finished = 0;

  // reference model state
  int m_st = 0, m_last = 0, m_tc = 0, m_idle = 0;
  bit m_pend = 0;
  logic [4:0] m_cause = '0;
  int pg_dly = 0, rs_dly = 0;
  int quiet_left = 0, drop_left = 0;

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [3:0] exp_ctl(input int s);
    case (s)
      0:       exp_ctl = 4'b0011;
      1, 8, 9: exp_ctl = 4'b1011;
      2, 7:    exp_ctl = 4'b1111;
      3, 6:    exp_ctl = 4'b1101;
      default: exp_ctl = 4'b1100;
    endcase
  endfunction

  function automatic string tag_of(input int s, input bit pend);
    case (s)
      0:       tag_of = "R2";
      1, 2, 3: tag_of = pend ? "R8" : "R3";
      4:       tag_of = pend ? "R8" : "R4";
      5:       tag_of = "R5";
      9:       tag_of = "R7";
      default: tag_of = "R6";
    endcase
  endfunction

  function automatic int next_state(input int s, input bit susp, input bit gw, input bit done);
    next_state = s;
    case (s)
      0: if (susp || !session_ok) next_state = 1;
      1: if (done) next_state = gw ? 0 : 2;
      2: if (done) next_state = gw ? 8 : 3;
      3: if (done) next_state = gw ? 7 : 4;
      4: if (!pwr_good) next_state = gw ? 6 : 5;
      5: if (gw) next_state = 6;
      6: if (pwr_good) next_state = 7;
      7: if (done) next_state = 8;
      8: if (done) next_state = hib_mode ? 9 : 0;
      9: if (restore_done) next_state = 0;
      default: next_state = 0;
    endcase
  endfunction

  // one clock: advance model with inputs seen at the edge, compare, then react
  task automatic tick();
    int nx;
    bit any;
    string t;
    @(negedge clk);
    any = |wake_evt;
    nx = next_state(m_st, m_idle == IDLE, m_pend | any, m_tc == 0);
    if (m_st != 0 && !m_pend && any) m_cause = wake_evt;
    m_pend = (m_st == 0) ? 1'b0 : (m_pend | any);
    m_idle = (m_st != 0 || bus_active) ? 0 : ((m_idle == IDLE) ? IDLE : m_idle + 1);
    if (nx != m_st) m_tc = int'(step_wait);
    else if (m_tc != 0) m_tc--;
    m_last = m_st;
    m_st = nx;
    t = tag_of(m_st, m_pend);
    check(t, int'(state_o), m_st);
    check("R11", int'({clamp_en, dom_rst, clk_en, pwr_sw_en}), int'(exp_ctl(m_st)));
    check("R7", int'(restore_req), int'(m_st == 9 && m_last != 9));
    check("R9", int'(wake_cause), int'(m_cause));
    // environment: supply follower and restore acknowledge
    restore_done = 1'b0;
    if (restore_req) rs_dly = 1 + int'($urandom % 4);
    else if (rs_dly > 0) begin
      rs_dly--;
      if (rs_dly == 0) restore_done = 1'b1;
    end
    if (pwr_good != pwr_sw_en) begin
      if (pg_dly == 0) pg_dly = 1 + int'($urandom % 4);
      else begin
        pg_dly--;
        if (pg_dly == 0) pwr_good = pwr_sw_en;
      end
    end else pg_dly = 0;
  endtask

  task automatic rand_drive(input int cyc);
    if (quiet_left > 0) begin quiet_left--; bus_active = 1'b0; end
    else begin
      bus_active = ($urandom % 3) != 0;
      if ($urandom % 120 == 0) quiet_left = 10 + int'($urandom % 50);
    end
    if (drop_left > 0) begin drop_left--; session_ok = 1'b0; end
    else begin
      session_ok = 1'b1;
      if ($urandom % 500 == 0) drop_left = 2 + int'($urandom % 10);
    end
    wake_evt = ($urandom % 14 == 0) ? 5'($urandom % 32) : 5'd0;
    if (cyc % 400 == 0) hib_mode = $urandom % 2;
    if (cyc % 250 == 0) step_wait = SWW'($urandom % 4);
  endtask

  initial begin
    #600000;
    if (!finished) begin
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    int seen;
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    // R1: reset state
    check("R1", int'(state_o), 0);
    check("R1", int'({clamp_en, dom_rst, clk_en, pwr_sw_en}), 4'b0011);
    check("R1", int'(restore_req), 0);
    check("R1", int'(wake_cause), 0);
    rst_n = 1'b1;
    tick();
    check("R1", int'(state_o), 0);

    // R10: wake events while running are ignored
    wake_evt = 5'h1F;
    repeat (4) tick();
    wake_evt = '0;
    tick();
    check("R10", int'(state_o), 0);
    check("R10", int'(wake_cause), 0);

    // R2: exact idle threshold
    bus_active = 1'b0;
    repeat (IDLE) tick();
    check("R2", int'(state_o), 0);
    tick();
    check("R2", int'(state_o), 1);

    // R9 and R5: full gate, wake by bus reset bit
    hib_mode = 1'b0; step_wait = SWW'(1);
    seen = 0;
    while (state_o != 4'd5 && seen < 200) begin tick(); seen++; end
    check("R5", int'(state_o), 5);
    repeat (3) tick();
    check("R5", int'(state_o), 5);
    wake_evt = 5'b00100;
    tick();
    wake_evt = '0;
    check("R5", int'(state_o), 6);
    seen = 0;
    while (state_o != 4'd0 && seen < 200) begin tick(); seen++; end
    bus_active = 1'b1;
    check("R9", int'(wake_cause), 5'b00100);
    check("R6", int'(clamp_en), 0);

    // R8: wake during clocks-stopped step reverses to clocks-running
    step_wait = SWW'(3);
    bus_active = 1'b0;
    seen = 0;
    while (state_o != 4'd3 && seen < 200) begin tick(); seen++; end
    wake_evt = 5'b00010;
    tick();
    wake_evt = '0;
    bus_active = 1'b1;
    seen = 0;
    while (state_o == 4'd3 && seen < 50) begin tick(); seen++; end
    check("R8", int'(state_o), 7);
    check("R9", int'(wake_cause), 5'b00010);

    // R7: hibernation path via session drop
    seen = 0;
    while (state_o != 4'd0 && seen < 200) begin tick(); seen++; end
    hib_mode = 1'b1; step_wait = '0;
    session_ok = 1'b0;
    tick();
    session_ok = 1'b1;
    check("R2", int'(state_o), 1);
    seen = 0;
    while (state_o != 4'd5 && seen < 200) begin tick(); seen++; end
    wake_evt = 5'b10000;
    tick();
    wake_evt = '0;
    seen = 0;
    while (state_o != 4'd9 && seen < 200) begin tick(); seen++; end
    check("R7", int'(state_o), 9);
    seen = 0;
    while (state_o != 4'd0 && seen < 200) begin tick(); seen++; end
    check("R7", int'(state_o), 0);

    // random phase
    for (int c = 0; c < 30000; c++) begin
      rand_drive(c);
      tick();
    end

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule